// File: doc/BRIEF.md
# Pulse-Interval Gap Write Decoder

This block receives the downlink that a reader sends to a tag. The reader sends data by briefly switching off its RF field. The block runs on the recovered field clock. It takes a field-present level that has already been synchronised to that clock. The end of each field interruption (a gap) is the rising edge of field-present. The block counts the field clocks between successive gap ends and sorts each interval into one of four outcomes: a 0 bit, a 1 bit, a malformed symbol, or the silence that closes the frame.

The first gap seen while idle is the start gap and opens write mode. It is honoured only once the configuration load has finished. A mode input selects normal or fast timing windows. Command interpretation and analog gap detection belong to other blocks. The downstream command logic takes each strobed bit and the running count. It acts on the frame only when the end pulse arrives with the error flag clear. A frame that closes with a zero count is a lone gap, and the selected page must not change.

Top module: `gap_write_decoder`

## Requirements
- R1: While `cfg_ready` is low, gaps are ignored and `wr_active` stays 0. While idle with `cfg_ready` high, the end of a gap sets `wr_active` on the following cycle. The start gap itself produces no bit.
- R2: With `fast_mode` = 0, an interval of 16 to 31 field clocks decodes as bit value 0 and an interval of 48 to 63 decodes as bit value 1.
- R3: With `fast_mode` = 1, an interval of 8 to 15 field clocks decodes as bit value 0 and an interval of 24 to 31 decodes as bit value 1.
- R4: The interval is the number of clock edges from one sampled rising edge of `field_on` to the next. A decoded bit raises `bit_stb` for exactly one cycle, in the cycle after the closing edge is sampled. `bit_val` carries the value and `bit_cnt` has already incremented in that same cycle.
- R5: In write mode, the frame closes when `field_on` stays high for more than 64 clocks (normal) or more than 32 clocks (fast) after the last gap end. `frame_done` pulses for one cycle and `wr_active` drops in that cycle, which is 65 (or 33) cycles after the last gap-end strobe cycle.
- R6: An interval outside both windows of the active mode sets `frame_err` in the next cycle and produces no strobe. `frame_err` holds until the next start gap, and every later interval of that frame produces no strobe and leaves `bit_cnt` unchanged.
- R7: `bit_cnt` clears at a start gap and holds its value after the frame closes, until the next start gap. A lone start gap closes with `frame_done`, `bit_cnt` = 0 and `frame_err` = 0.
- R8: The interval counter saturates instead of wrapping. An interval of 148 clocks is therefore reported as an error, even though 148 modulo 128 would fall in the 0-bit window.
- R9: After reset, `bit_stb`, `bit_val`, `bit_cnt`, `wr_active`, `frame_done` and `frame_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Field clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ready | input | 1 | Configuration load complete; start gaps are honoured only when high |
| fast_mode | input | 1 | 0 selects normal timing windows, 1 selects fast |
| field_on | input | 1 | Synchronised field-present level; low during a gap |
| bit_stb | output | 1 | One-cycle pulse per decoded bit |
| bit_val | output | 1 | Value of the most recently strobed bit |
| bit_cnt | output | BCNT_W (7) | Bits decoded in the current or last frame, saturating |
| wr_active | output | 1 | Write mode open |
| frame_done | output | 1 | One-cycle pulse when the silence timeout closes the frame |
| frame_err | output | 1 | Malformed interval seen in this frame |

## Verification
Every result is registered once behind the clock edge that first sees `field_on` high again. The strobe, the bit value, the incremented count, the error flag and the write-mode rise therefore all become visible in the cycle after that edge. The bench drives `field_on` on falling edges and reads the outputs on the next falling edge after the gap ends. The frame-close pulse is due exactly 64 (normal) or 32 (fast) falling edges after that sample point plus one. The bench checks that the pulse is still low one edge earlier and high on the due edge. Every interval from just above the gap length up to the timeout limit is swept in both modes, and each strobe is compared against a window computed arithmetically in the bench.

// File: rtl/gapdec_pkg.sv
package gapdec_pkg;

    // Outcome of one measured interval
    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_ONE  = 2'd1,
        SYM_BAD  = 2'd2
    } sym_e;

    // Receiver states
    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RECV = 1'b1
    } rx_state_e;

    // Timing windows, all in field clocks (8 bits is enough for every mode)
    localparam int WIN_W = 8;

    typedef struct packed {
        logic [WIN_W-1:0] zero_lo;
        logic [WIN_W-1:0] zero_hi;
        logic [WIN_W-1:0] one_lo;
        logic [WIN_W-1:0] one_hi;
        logic [WIN_W-1:0] quiet_max;   // silence longer than this closes the frame
    } win_t;

    localparam win_t WIN_NORMAL = '{zero_lo: 8'd16, zero_hi: 8'd31,
                                    one_lo: 8'd48,  one_hi: 8'd63,
                                    quiet_max: 8'd64};
    localparam win_t WIN_FAST   = '{zero_lo: 8'd8,  zero_hi: 8'd15,
                                    one_lo: 8'd24,  one_hi: 8'd31,
                                    quiet_max: 8'd32};

    function automatic win_t window_of(input logic fast);
        return fast ? WIN_FAST : WIN_NORMAL;
    endfunction

    function automatic sym_e classify(input logic [WIN_W-1:0] n, input win_t w);
        if (n >= w.zero_lo && n <= w.zero_hi)
            return SYM_ZERO;
        else if (n >= w.one_lo && n <= w.one_hi)
            return SYM_ONE;
        else
            return SYM_BAD;
    endfunction

endpackage

// File: rtl/gapdec_edge.sv
// Detects the end of a gap: field seen present after being absent.
module gapdec_edge (
    input  logic clk,
    input  logic rst,
    input  logic field_on,
    output logic gap_end
);
    logic field_q;

    always_ff @(posedge clk) begin
        if (rst)
            field_q <= 1'b1;   // treat the field as present out of reset
        else
            field_q <= field_on;
    end

    assign gap_end = field_on & ~field_q;
endmodule

// File: rtl/gapdec_interval.sv
// Counts field clocks since the last gap end; saturates at all-ones.
module gapdec_interval #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (restart)
            count <= CNT_ONE;
        else if (count != CNT_MAX)
            count <= count + CNT_ONE;
    end
endmodule

// File: rtl/gapdec_ctrl.sv
// Frame control: opens on a start gap, classifies intervals, closes on silence.
module gapdec_ctrl
    import gapdec_pkg::*;
#(
    parameter int CNT_W  = 7,
    parameter int BCNT_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_ready,
    input  logic              fast_mode,
    input  logic              field_on,
    input  logic              gap_end,
    input  logic [CNT_W-1:0]  ival,
    output logic              bit_stb,
    output logic              bit_val,
    output logic [BCNT_W-1:0] bit_cnt,
    output logic              wr_active,
    output logic              frame_done,
    output logic              frame_err
);
    localparam logic [BCNT_W-1:0] BCNT_MAX = '1;
    localparam logic [BCNT_W-1:0] BCNT_ONE = BCNT_W'(1);

    rx_state_e        state_q;
    win_t             win;
    sym_e             sym;
    logic [WIN_W-1:0] ival_w;
    logic             quiet_hit;

    assign ival_w    = WIN_W'(ival);
    assign win       = window_of(fast_mode);
    assign sym       = classify(ival_w, win);
    assign quiet_hit = field_on && !gap_end && (ival_w > win.quiet_max);
    assign wr_active = (state_q == RX_RECV);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= RX_IDLE;
            bit_stb    <= 1'b0;
            bit_val    <= 1'b0;
            bit_cnt    <= '0;
            frame_done <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            bit_stb    <= 1'b0;
            frame_done <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    if (cfg_ready && gap_end) begin
                        state_q   <= RX_RECV;
                        bit_cnt   <= '0;
                        frame_err <= 1'b0;
                    end
                end
                RX_RECV: begin
                    if (gap_end) begin
                        if (!frame_err) begin
                            if (sym == SYM_BAD) begin
                                frame_err <= 1'b1;
                            end else begin
                                bit_stb <= 1'b1;
                                bit_val <= (sym == SYM_ONE);
                                if (bit_cnt != BCNT_MAX)
                                    bit_cnt <= bit_cnt + BCNT_ONE;
                            end
                        end
                    end else if (quiet_hit) begin
                        state_q    <= RX_IDLE;
                        frame_done <= 1'b1;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/gap_write_decoder.sv
module gap_write_decoder #(
    parameter int CNT_W  = 7,
    parameter int BCNT_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_ready,
    input  logic              fast_mode,
    input  logic              field_on,
    output logic              bit_stb,
    output logic              bit_val,
    output logic [BCNT_W-1:0] bit_cnt,
    output logic              wr_active,
    output logic              frame_done,
    output logic              frame_err
);
    logic             gap_end;
    logic [CNT_W-1:0] ival_cnt;

    gapdec_edge edge_i (
        .clk      (clk),
        .rst      (rst),
        .field_on (field_on),
        .gap_end  (gap_end)
    );

    gapdec_interval #(.CNT_W(CNT_W)) ival_i (
        .clk     (clk),
        .rst     (rst),
        .restart (gap_end),
        .count   (ival_cnt)
    );

    gapdec_ctrl #(.CNT_W(CNT_W), .BCNT_W(BCNT_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_ready  (cfg_ready),
        .fast_mode  (fast_mode),
        .field_on   (field_on),
        .gap_end    (gap_end),
        .ival       (ival_cnt),
        .bit_stb    (bit_stb),
        .bit_val    (bit_val),
        .bit_cnt    (bit_cnt),
        .wr_active  (wr_active),
        .frame_done (frame_done),
        .frame_err  (frame_err)
    );
endmodule

// File: rtl/gap_write_decoder_chk.sv
module gap_write_decoder_chk #(
    parameter int CNT_W  = 7,
    parameter int BCNT_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_ready,
    input logic              fast_mode,
    input logic              bit_stb,
    input logic              bit_val,
    input logic [BCNT_W-1:0] bit_cnt,
    input logic              wr_active,
    input logic              frame_done,
    input logic              frame_err,
    input logic [CNT_W-1:0]  ival
);
    localparam logic [CNT_W-1:0] IMAX = '1;

    // R1: write mode opens only with configuration loaded
    p_open_needs_cfg_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_active) |-> $past(cfg_ready));

    // R1: no bits outside write mode
    p_no_stb_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !wr_active |-> !bit_stb);

    // R2: normal-mode strobes come from the normal windows
    p_norm_window_r2: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && !$past(fast_mode)) |->
            ((int'($past(ival)) >= 16 && int'($past(ival)) <= 31 && !bit_val) ||
             (int'($past(ival)) >= 48 && int'($past(ival)) <= 63 && bit_val)));

    // R3: fast-mode strobes come from the fast windows
    p_fast_window_r3: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && $past(fast_mode)) |->
            ((int'($past(ival)) >= 8 && int'($past(ival)) <= 15 && !bit_val) ||
             (int'($past(ival)) >= 24 && int'($past(ival)) <= 31 && bit_val)));

    // R4: strobe lasts one cycle
    p_stb_single_r4: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);

    // R5: end pulse is one cycle and coincides with leaving write mode
    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);
    p_done_closes_r5: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (!wr_active && $past(wr_active)));

    // R6: an errored frame emits no bits
    p_err_mutes_r6: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> !bit_stb);

    // R7: bit count frozen while idle
    p_cnt_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!wr_active && $past(!wr_active)) |-> $stable(bit_cnt));

    // R8: interval counter never wraps from its ceiling
    p_ival_sat_r8: assert property (@(posedge clk) disable iff (rst)
        (ival == IMAX) |=> (ival == IMAX || ival == CNT_W'(1)));
endmodule

bind gap_write_decoder gap_write_decoder_chk #(.CNT_W(CNT_W), .BCNT_W(BCNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_ready  (cfg_ready),
    .fast_mode  (fast_mode),
    .bit_stb    (bit_stb),
    .bit_val    (bit_val),
    .bit_cnt    (bit_cnt),
    .wr_active  (wr_active),
    .frame_done (frame_done),
    .frame_err  (frame_err),
    .ival       (ival_cnt)
);

// File: tb/gap_write_decoder_tb_top.sv
module gap_write_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_ready = 1'b0;
    logic       fast_mode = 1'b0;
    logic       field_on = 1'b1;
    logic       bit_stb, bit_val, wr_active, frame_done, frame_err;
    logic [6:0] bit_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    gap_write_decoder dut_i (
        .clk(clk), .rst(rst), .cfg_ready(cfg_ready), .fast_mode(fast_mode),
        .field_on(field_on), .bit_stb(bit_stb), .bit_val(bit_val),
        .bit_cnt(bit_cnt), .wr_active(wr_active), .frame_done(frame_done),
        .frame_err(frame_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // 0 / 1 for a valid bit, 2 for a malformed interval
    function automatic int exp_sym(input int n, input bit fast);
        if (fast) begin
            if (n >= 8 && n <= 15) return 0;
            if (n >= 24 && n <= 31) return 1;
        end else begin
            if (n >= 16 && n <= 31) return 0;
            if (n >= 48 && n <= 63) return 1;
        end
        return 2;
    endfunction

    // Gap of g clocks, then field back; returns one falling edge after the gap end is sampled
    task automatic start_gap(input int g, input bit expect_open);
        field_on = 1'b0;
        repeat (g) @(negedge clk);
        field_on = 1'b1;
        @(negedge clk);
        chk("R1 write mode after start gap", wr_active, expect_open);
        chk("R1 no strobe on start gap", bit_stb, 0);
        if (expect_open) begin
            chk("R7 count cleared at start", bit_cnt, 0);
            chk("R6 error cleared at start", frame_err, 0);
        end
    endtask

    // Interval of n clocks (gap of g inside it), measured from the previous gap end
    task automatic send(input int n, input int g);
        repeat (n - g - 1) @(negedge clk);
        field_on = 1'b0;
        repeat (g) @(negedge clk);
        field_on = 1'b1;
        @(negedge clk);
    endtask

    // Wait for the silence timeout right after a gap-end sample point
    task automatic close_frame(input bit fast, input int cnt_exp, input int err_exp);
        int lim;
        lim = fast ? 32 : 64;
        @(negedge clk);
        chk("R4 strobe single cycle", bit_stb, 0);
        repeat (lim - 1) @(negedge clk);
        chk("R5 no close before limit", frame_done, 0);
        chk("R5 still in write mode", wr_active, 1);
        @(negedge clk);
        chk("R5 close pulse", frame_done, 1);
        chk("R5 write mode left", wr_active, 0);
        chk("R7 count at close", bit_cnt, cnt_exp);
        chk("R6 error at close", frame_err, err_exp);
        @(negedge clk);
        chk("R5 close pulse single", frame_done, 0);
    endtask

    task automatic one_bit_frame(input int n, input int g, input bit fast);
        int s;
        fast_mode = fast;
        s = exp_sym(n, fast);
        start_gap(12, 1'b1);
        send(n, g);
        if (s < 2) begin
            chk(fast ? "R3 strobe" : "R2 strobe", bit_stb, 1);
            chk(fast ? "R3 value" : "R2 value", bit_val, s);
            chk("R4 count with strobe", bit_cnt, 1);
            chk("R6 no error", frame_err, 0);
        end else begin
            chk("R6 no strobe on bad interval", bit_stb, 0);
            chk("R6 error flag", frame_err, 1);
            chk("R6 count unchanged", bit_cnt, 0);
        end
        close_frame(fast, (s < 2) ? 1 : 0, (s < 2) ? 0 : 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 bit_stb", bit_stb, 0);
        chk("R9 bit_val", bit_val, 0);
        chk("R9 bit_cnt", bit_cnt, 0);
        chk("R9 wr_active", wr_active, 0);
        chk("R9 frame_done", frame_done, 0);
        chk("R9 frame_err", frame_err, 0);

        // R1: gaps ignored before configuration is loaded
        repeat (5) @(negedge clk);
        start_gap(20, 1'b0);
        send(24, 8);
        chk("R1 no bit before config", bit_stb, 0);
        chk("R1 still idle", wr_active, 0);
        repeat (70) @(negedge clk);
        cfg_ready = 1'b1;
        repeat (5) @(negedge clk);

        // R7: lone start gap
        fast_mode = 1'b0;
        start_gap(30, 1'b1);
        close_frame(1'b0, 0, 0);

        // R2 / R3 sweeps over every interval below the timeout
        for (int n = 9; n <= 64; n++) one_bit_frame(n, 8, 1'b0);
        for (int n = 5; n <= 32; n++) one_bit_frame(n, 4, 1'b1);

        // R2 / R4: multi-bit normal frame
        fast_mode = 1'b0;
        start_gap(15, 1'b1);
        for (int i = 0; i < 8; i++) begin
            bit b;
            b = (8'hB2 >> (7 - i)) & 1'b1;
            send(b ? 56 : 24, 10);
            chk("R4 strobe in stream", bit_stb, 1);
            chk("R2 value in stream", bit_val, b);
            chk("R4 running count", bit_cnt, i + 1);
        end
        close_frame(1'b0, 8, 0);
        repeat (20) @(negedge clk);
        chk("R7 count held after close", bit_cnt, 8);

        // R3: multi-bit fast frame
        fast_mode = 1'b1;
        start_gap(10, 1'b1);
        for (int i = 0; i < 5; i++) begin
            bit b;
            b = (5'b10110 >> (4 - i)) & 1'b1;
            send(b ? 28 : 12, 6);
            chk("R3 value in fast stream", bit_val, b);
            chk("R4 fast running count", bit_cnt, i + 1);
        end
        close_frame(1'b1, 5, 0);

        // R6: error suppresses the rest of the frame
        fast_mode = 1'b0;
        start_gap(12, 1'b1);
        send(20, 8);
        chk("R2 first bit", bit_val, 0);
        send(40, 8);
        chk("R6 bad interval flagged", frame_err, 1);
        send(56, 8);
        chk("R6 later bit suppressed", bit_stb, 0);
        chk("R6 count frozen", bit_cnt, 1);
        close_frame(1'b0, 1, 1);
        start_gap(12, 1'b1);
        close_frame(1'b0, 0, 0);

        // R8: 148-clock interval must not wrap into the 0 window
        start_gap(12, 1'b1);
        send(148, 147);
        chk("R8 no strobe on saturated interval", bit_stb, 0);
        chk("R8 saturated interval is an error", frame_err, 1);
        close_frame(1'b0, 0, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule